// File: doc/BRIEF.md
# Segment-Then-Page Address Translator

This block turns a logical address into a physical address through two dependent table lookups. The logical address is split, from its most significant end downward, into a segment number, a virtual page number and a page offset. The block first fetches the descriptor of the selected segment from the current process's segment table. That descriptor holds the base of a page table that belongs only to that segment, together with the segment's length counted in whole pages. The block then fetches the page entry at that base plus the virtual page number. It joins the frame number found there to the unchanged offset.

A request is accepted with a valid/ready handshake. Both lookups go through one shared memory read port, one after the other. A read is held until the memory acknowledges it, and the entry data arrives in the acknowledge cycle. The result comes back as a single-cycle response that carries either the physical address or a code naming the level that failed. A failure can be an absent segment, a page number outside the segment, or an absent page. Loading missing pages and any software handling sit outside this block.

Top module: `segpage_xlate`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, and `mem_rd_req`, `rsp_valid` and `rsp_paddr` are all 0.
- R2: The first read of each translation goes to address `stbr + seg`, taken modulo 2^MEM_AW. Here `stbr` is the value sampled in the cycle the request is accepted, and `seg` is the top SEG_W bits of `req_laddr`.
- R3: A segment entry has its valid flag in bit MEM_DW-1. If that flag is 0, the response carries fault code 1, `rsp_paddr` is 0 and no page read is made.
- R4: The segment length in pages sits in bits [MEM_AW+VPN_W:MEM_AW] of the segment entry. If the entry is valid and the virtual page number is greater than or equal to that length, the response carries fault code 2 and no page read is made.
- R5: The second read goes to `pt_base + vpn`, taken modulo 2^MEM_AW. Here `pt_base` is bits [MEM_AW-1:0] of the segment entry, so a page table may wrap past the top of the address space.
- R6: A page entry has its valid flag in bit MEM_DW-1. If that flag is 0, the response carries fault code 3 and `rsp_paddr` is 0.
- R7: When both entries are valid and the page is in range, the response carries fault code 0. `rsp_paddr` is then the frame number from page-entry bits [PFN_W-1:0] joined above the original offset.
- R8: Each table level makes exactly one read. `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack` is sampled, and there is no read once the response is due.
- R9: `rsp_valid` is high for exactly one cycle per translation. `req_ready` is 0 from acceptance until after the response, and `req_valid` is ignored during that time.
- R10: A change of `stbr` after acceptance has no effect on the translation in progress.
- R11: An invalid segment entry reports fault code 1 even when the page number is also out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stbr | input | MEM_AW | Base address of the segment table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | SEG_W+VPN_W+OFF_W | Logical address, laid out as {segment, page, offset} |
| mem_rd_req | output | 1 | Table read request, held until acknowledged |
| mem_rd_addr | output | MEM_AW | Table entry address |
| mem_rd_ack | input | 1 | Read done; data valid in this cycle |
| mem_rd_data | input | MEM_DW | Table entry data |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 2 | 0 none, 1 segment absent, 2 page out of range, 3 page absent |
| rsp_paddr | output | PFN_W+OFF_W | Physical address; 0 unless fault code is 0 |

## Verification
The bench builds the block with SEG_W=2, VPN_W=3, OFF_W=4, PFN_W=5, MEM_AW=8 and MEM_DW=16. At these sizes every one of the 32 segment/page pairs can be swept, including segments of length 0 and of the full length 8. One page table is placed at address 0xFC, so the page-address sum wraps. The memory latency is varied from zero to three wait cycles, which stresses how the read is held. While a walk is under way, the bench also drives a second request and a changed table base, and neither may leak into the result.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEG  = 2'd1,
    ST_PAGE = 2'd2,
    ST_RESP = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_SEG_ABSENT  = 2'd1,
    FLT_PAGE_RANGE  = 2'd2,
    FLT_PAGE_ABSENT = 2'd3
  } walk_fault_e;

endpackage

// File: rtl/segpage_entry_decode.sv
module segpage_entry_decode #(
  parameter int MEM_AW = 8,
  parameter int MEM_DW = 16,
  parameter int VPN_W  = 3,
  parameter int PFN_W  = 5
) (
  input  logic [MEM_DW-1:0] rdata,
  input  logic [VPN_W-1:0]  vpn,
  output logic              seg_valid,
  output logic [MEM_AW-1:0] seg_pt_base,
  output logic [VPN_W:0]    seg_len,
  output logic              vpn_in_range,
  output logic              pg_valid,
  output logic [PFN_W-1:0]  pg_pfn
);

  localparam int LEN_LO = MEM_AW;
  localparam int LEN_HI = MEM_AW + VPN_W;
  localparam int VLD    = MEM_DW - 1;

  function automatic logic page_fits(input logic [VPN_W-1:0] v,
                                     input logic [VPN_W:0]   len);
    return {1'b0, v} < len;
  endfunction

  always_comb begin
    seg_valid    = rdata[VLD];
    seg_pt_base  = rdata[MEM_AW-1:0];
    seg_len      = rdata[LEN_HI:LEN_LO];
    vpn_in_range = page_fits(vpn, seg_len);
    pg_valid     = rdata[VLD];
    pg_pfn       = rdata[PFN_W-1:0];
  end

endmodule

// File: rtl/segpage_addr_gen.sv
module segpage_addr_gen
  import segpage_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int SEG_W  = 2,
  parameter int VPN_W  = 3
) (
  input  walk_state_e       state,
  input  logic [MEM_AW-1:0] stbr_q,
  input  logic [SEG_W-1:0]  seg_q,
  input  logic [MEM_AW-1:0] pt_base_q,
  input  logic [VPN_W-1:0]  vpn_q,
  output logic              rd_req,
  output logic [MEM_AW-1:0] rd_addr
);

  function automatic logic [MEM_AW-1:0] seg_slot(input logic [MEM_AW-1:0] base,
                                                 input logic [SEG_W-1:0]  s);
    return base + {{(MEM_AW-SEG_W){1'b0}}, s};
  endfunction

  function automatic logic [MEM_AW-1:0] page_slot(input logic [MEM_AW-1:0] base,
                                                  input logic [VPN_W-1:0]  v);
    return base + {{(MEM_AW-VPN_W){1'b0}}, v};
  endfunction

  always_comb begin
    rd_req  = 1'b0;
    rd_addr = '0;
    case (state)
      ST_SEG: begin
        rd_req  = 1'b1;
        rd_addr = seg_slot(stbr_q, seg_q);
      end
      ST_PAGE: begin
        rd_req  = 1'b1;
        rd_addr = page_slot(pt_base_q, vpn_q);
      end
      default: begin
        rd_req  = 1'b0;
        rd_addr = '0;
      end
    endcase
  end

endmodule

// File: rtl/segpage_fsm.sv
module segpage_fsm
  import segpage_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_rd_ack,
  input  logic        seg_valid,
  input  logic        vpn_in_range,
  input  logic        pg_valid,
  output walk_state_e state,
  output walk_fault_e fault_q,
  output logic        accept,
  output logic        seg_ack,
  output logic        page_ack
);

  walk_state_e state_nx;
  walk_fault_e fault_nx;

  assign accept   = (state == ST_IDLE) && req_valid;
  assign seg_ack  = (state == ST_SEG) && mem_rd_ack;
  assign page_ack = (state == ST_PAGE) && mem_rd_ack;

  always_comb begin
    state_nx = state;
    fault_nx = fault_q;
    case (state)
      ST_IDLE: if (accept) begin
        state_nx = ST_SEG;
        fault_nx = FLT_NONE;
      end
      ST_SEG: if (seg_ack) begin
        if (!seg_valid) begin
          fault_nx = FLT_SEG_ABSENT;
          state_nx = ST_RESP;
        end else if (!vpn_in_range) begin
          fault_nx = FLT_PAGE_RANGE;
          state_nx = ST_RESP;
        end else begin
          state_nx = ST_PAGE;
        end
      end
      ST_PAGE: if (page_ack) begin
        if (!pg_valid) fault_nx = FLT_PAGE_ABSENT;
        state_nx = ST_RESP;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fault_q <= FLT_NONE;
    end else begin
      state   <= state_nx;
      fault_q <= fault_nx;
    end
  end

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segpage_pkg::*;
#(
  parameter int SEG_W  = 2,
  parameter int VPN_W  = 3,
  parameter int OFF_W  = 4,
  parameter int PFN_W  = 5,
  parameter int MEM_AW = 8,
  parameter int MEM_DW = 16,
  localparam int LA_W  = SEG_W + VPN_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] stbr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  output logic              mem_rd_req,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [MEM_DW-1:0] mem_rd_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);

  localparam int OFF_LO = 0;
  localparam int VPN_LO = OFF_W;
  localparam int SEG_LO = OFF_W + VPN_W;

  walk_state_e       state;
  walk_fault_e       fault_q;
  logic              accept;
  logic              evt_seg_ack;
  logic              evt_page_ack;
  logic              evt_seg_fault;

  logic [SEG_W-1:0]  seg_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [MEM_AW-1:0] stbr_q;
  logic [MEM_AW-1:0] pt_base_q;
  logic [PFN_W-1:0]  pfn_q;

  logic              seg_valid;
  logic [MEM_AW-1:0] seg_pt_base;
  logic [VPN_W:0]    seg_len;
  logic              vpn_in_range;
  logic              pg_valid;
  logic [PFN_W-1:0]  pg_pfn;

  segpage_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rd_ack   (mem_rd_ack),
    .seg_valid    (seg_valid),
    .vpn_in_range (vpn_in_range),
    .pg_valid     (pg_valid),
    .state        (state),
    .fault_q      (fault_q),
    .accept       (accept),
    .seg_ack      (evt_seg_ack),
    .page_ack     (evt_page_ack)
  );

  segpage_entry_decode #(
    .MEM_AW (MEM_AW),
    .MEM_DW (MEM_DW),
    .VPN_W  (VPN_W),
    .PFN_W  (PFN_W)
  ) u_dec (
    .rdata        (mem_rd_data),
    .vpn          (vpn_q),
    .seg_valid    (seg_valid),
    .seg_pt_base  (seg_pt_base),
    .seg_len      (seg_len),
    .vpn_in_range (vpn_in_range),
    .pg_valid     (pg_valid),
    .pg_pfn       (pg_pfn)
  );

  segpage_addr_gen #(
    .MEM_AW (MEM_AW),
    .SEG_W  (SEG_W),
    .VPN_W  (VPN_W)
  ) u_agen (
    .state     (state),
    .stbr_q    (stbr_q),
    .seg_q     (seg_q),
    .pt_base_q (pt_base_q),
    .vpn_q     (vpn_q),
    .rd_req    (mem_rd_req),
    .rd_addr   (mem_rd_addr)
  );

  assign evt_seg_fault = evt_seg_ack && (!seg_valid || !vpn_in_range);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= '0;
      vpn_q     <= '0;
      off_q     <= '0;
      stbr_q    <= '0;
      pt_base_q <= '0;
      pfn_q     <= '0;
    end else begin
      if (accept) begin
        seg_q  <= req_laddr[SEG_LO +: SEG_W];
        vpn_q  <= req_laddr[VPN_LO +: VPN_W];
        off_q  <= req_laddr[OFF_LO +: OFF_W];
        stbr_q <= stbr;
        pfn_q  <= '0;
      end
      if (evt_seg_ack) pt_base_q <= seg_pt_base;
      if (evt_page_ack && pg_valid) pfn_q <= pg_pfn;
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    rsp_valid = (state == ST_RESP);
    rsp_fault = rsp_valid ? fault_q : FLT_NONE;
    rsp_paddr = (rsp_valid && fault_q == FLT_NONE) ? {pfn_q, off_q} : '0;
  end

endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk #(
  parameter int MEM_AW = 8,
  parameter int PA_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_rd_req,
  input logic [MEM_AW-1:0] mem_rd_addr,
  input logic              mem_rd_ack,
  input logic              rsp_valid,
  input logic [1:0]        rsp_fault,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              evt_seg_fault,
  input logic              evt_page_ack
);

  p_hold_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  p_one_page_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_page_ack |=> (!mem_rd_req && rsp_valid));

  p_seg_fault_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_seg_fault |=> (rsp_valid && rsp_fault != 2'd0 && !mem_rd_req));

  p_fault_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || rsp_valid) |-> !req_ready);

endmodule

bind segpage_xlate segpage_xlate_chk #(
  .MEM_AW (MEM_AW),
  .PA_W   (PA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_rd_req    (mem_rd_req),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rd_ack    (mem_rd_ack),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_paddr     (rsp_paddr),
  .evt_seg_fault (evt_seg_fault),
  .evt_page_ack  (evt_page_ack)
);

// File: tb/segpage_xlate_tb_top.sv
module segpage_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  stbr = 8'h0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [8:0]  req_laddr = 9'h0;
  logic        mem_rd_req;
  logic [7:0]  mem_rd_addr;
  logic        ack_r = 1'b0;
  logic [15:0] data_r = 16'h0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [8:0]  rsp_paddr;

  int total = 0;
  int bad = 0;
  int mem_lat = 0;
  int lat_cnt = 0;
  int cycles = 0;
  logic [15:0] mem [256];
  int rd_log[$];

  always #10 clk = ~clk;

  segpage_xlate dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stbr        (stbr),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_laddr   (req_laddr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (ack_r),
    .mem_rd_data (data_r),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr)
  );

  // memory model with programmable wait cycles; logs each completed read
  always @(posedge clk) begin
    if (!rst_n) begin
      ack_r   <= 1'b0;
      lat_cnt <= 0;
    end else if (ack_r) begin
      ack_r   <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_rd_req) begin
      if (lat_cnt >= mem_lat) begin
        ack_r  <= 1'b1;
        data_r <= mem[mem_rd_addr];
        rd_log.push_back(int'(mem_rd_addr));
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic run(input int seg, input int vpn, input int off,
                     input int sb, input int lat);
    int e_fault, e_paddr, e_n, a0, a1, se, len, pe, n;
    bit busy_bad;
    // behavioural reference of the walk
    a0 = (sb + seg) % 256;
    a1 = 0;
    se = int'(mem[a0]);
    e_paddr = 0;
    if (se[15] == 1'b0) begin
      e_fault = 1; e_n = 1;                               // R3, R11
    end else begin
      len = (se / 256) % 16;
      if (vpn >= len) begin
        e_fault = 2; e_n = 1;                             // R4
      end else begin
        a1 = ((se % 256) + vpn) % 256;                    // R5
        pe = int'(mem[a1]);
        e_n = 2;
        if (pe[15] == 1'b0) e_fault = 3;                  // R6
        else begin
          e_fault = 0;
          e_paddr = (pe % 32) * 16 + off;                 // R7
        end
      end
    end

    @(negedge clk);
    mem_lat   = lat;
    stbr      = sb[7:0];
    req_laddr = 9'((seg * 128) + (vpn * 16) + off);
    req_valid = 1'b1;
    rd_log.delete();
    chk(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    // R10 base change and R9 second request during the walk
    stbr      = ~sb[7:0];
    req_laddr = ~req_laddr;
    busy_bad  = 1'b0;
    n = 0;
    while (!rsp_valid && n < 60) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R9 response arrives", int'(rsp_valid), 1);
    chk(!busy_bad, "R9 not ready while busy", int'(busy_bad), 0);
    chk(int'(rsp_fault) == e_fault, "R3/R4/R6/R11 fault code", int'(rsp_fault), e_fault);
    chk(int'(rsp_paddr) == e_paddr, "R7 physical address", int'(rsp_paddr), e_paddr);
    chk(rd_log.size() == e_n, "R8 read count", rd_log.size(), e_n);
    if (rd_log.size() >= 1)
      chk(rd_log[0] == a0, "R2/R10 segment entry address", rd_log[0], a0);
    if (rd_log.size() >= 2 && e_n == 2)
      chk(rd_log[1] == a1, "R5 page entry address", rd_log[1], a1);
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 single-cycle pulse",
        int'(rsp_valid), 0);
    @(negedge clk);
    chk(mem_rd_req == 1'b0, "R9 ignored request left no walk", int'(mem_rd_req), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    // segment table at 0x10
    mem[8'h10] = 16'h8440;  // valid, 4 pages, table at 0x40
    mem[8'h11] = 16'h0440;  // absent segment
    mem[8'h12] = 16'h88FC;  // valid, 8 pages, table at 0xFC (wraps)
    mem[8'h13] = 16'h8060;  // valid, 0 pages
    // page table of segment 0
    mem[8'h40] = 16'h8015;
    mem[8'h41] = 16'h0007;
    mem[8'h42] = 16'h801F;
    mem[8'h43] = 16'h8000;
    // page table of segment 2
    mem[8'hFC] = 16'h801A;
    mem[8'hFD] = 16'h8002;
    mem[8'hFE] = 16'h0000;
    mem[8'hFF] = 16'h8004;
    mem[8'h00] = 16'h8009;
    mem[8'h01] = 16'h8003;
    mem[8'h02] = 16'h0011;
    mem[8'h03] = 16'h8011;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(mem_rd_req == 1'b0, "R1 no read in reset", int'(mem_rd_req), 0);
    chk(rsp_valid == 1'b0, "R1 no response in reset", int'(rsp_valid), 0);
    chk(rsp_paddr == 9'h0, "R1 address zero in reset", int'(rsp_paddr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_rd_req == 1'b0, "R1 idle after release",
        int'(mem_rd_req), 0);

    // directed cases
    run(0, 0, 10, 16'h10, 0);   // R7 plain hit
    run(0, 1, 3, 16'h10, 1);    // R6 absent page
    run(0, 3, 15, 16'h10, 2);   // R4 last page in range, frame 0
    run(0, 4, 1, 16'h10, 0);    // R4 first page out of range
    run(1, 2, 5, 16'h10, 3);    // R3 absent segment
    run(1, 6, 5, 16'h10, 1);    // R11 absent and out of range
    run(2, 5, 7, 16'h10, 2);    // R5 page table wraps
    run(3, 0, 0, 16'h10, 0);    // R4 zero-length segment
    run(0, 0, 0, 16'h20, 1);    // R3 empty segment table
    run(3, 1, 9, 16'hFE, 3);    // R2 segment slot wraps

    // sweep of every segment/page pair with varied latency
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 8; v++)
        run(s, v, (s * 5 + v) % 16, 16'h10, (s + v) % 4);

    finish_run();
  end

endmodule